// File: doc/BRIEF.md
# I/O Port Permission Checker

This block decides whether a port I/O access of one, two or four bytes may go ahead, using the permission bitmap held in the task-state segment. A requester supplies the port number, the access size and the current task-state segment descriptor (present flag, type, base and limit), then pulses `start`. The block first screens the descriptor. If the descriptor passes, it fetches the bitmap start offset from the segment and checks that the two bitmap bytes it needs lie inside the segment limit. It then fetches those bytes and tests the bits that belong to the accessed ports.

The result is either a one-cycle `permitOk` pulse or a one-cycle `gpFault` pulse. A fault is always a general-protection fault whose error code is zero, so no code field is carried. Memory is reached through a 16-bit read port into kernel space, and at most one read is outstanding at a time. The privilege test that decides whether the bitmap is consulted at all, and the loading of the descriptor, belong to the surrounding logic.

Top module: `io_perm_checker`

## Requirements
- R1: After reset, `busy`, `memReq`, `permitOk` and `gpFault` are all 0.
- R2: The descriptor captured at start is valid only when its present flag is 1, its 4-bit type equals 4'b1001 and its limit is at least 103. Otherwise `gpFault` pulses one clock edge after the start edge, and no memory read is issued.
- R3: The first read fetches the 16-bit bitmap start offset from address base + 0x66. Read data is little-endian: bits 7:0 come from the lower byte address.
- R4: The bitmap byte offset is the fetched start offset plus the port number shifted right by 3. The second read is at base + that offset.
- R5: When the offset plus 1 is greater than the limit, `gpFault` pulses and no second read is issued. When it equals the limit, the check proceeds. The sum is formed wide enough that it never wraps, even with start offset 0xFFFF and port 0xFFFF.
- R6: The second read word is shifted right by port[2:0] and masked to its low 1, 2 or 4 bits for size code 2'b00, 2'b01 or 2'b10/2'b11. The access is permitted only when all the masked bits are 0.
- R7: Each accepted check ends with exactly one one-cycle pulse, on either `permitOk` or `gpFault` and never on both.
- R8: `busy` is high from the edge after an accepted start until the result pulse. A `start` seen while busy is ignored. Port, size and descriptor inputs are captured at the accepted start, and later changes to them have no effect on that check.
- R9: `memReq` stays high with a stable `memAddr` until `memAck`. Data is taken on the acknowledging edge, and the two reads never overlap.
- R10: With zero-wait memory, the result pulse appears 1, 3 or 5 edges after the start edge, for a descriptor fault, a bound fault and a bitmap decision respectively. Each memory wait cycle adds one edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a check (accepted only when idle) |
| portNum | input | 16 | I/O port number |
| accSize | input | 2 | Size code: 00 byte, 01 word, 10/11 dword |
| segPresent | input | 1 | Segment descriptor present flag |
| segType | input | 4 | Segment descriptor type field |
| segBase | input | 32 | Segment linear base address |
| segLimit | input | 32 | Segment limit |
| memReq | output | 1 | Memory read request |
| memAddr | output | 32 | Memory read byte address |
| memAck | input | 1 | Read acknowledge, data valid this cycle |
| memData | input | 16 | Read data, little-endian |
| busy | output | 1 | A check is in progress |
| permitOk | output | 1 | One-cycle pulse: access allowed |
| gpFault | output | 1 | One-cycle pulse: general-protection fault, error code 0 |

## Verification
With zero-wait memory, results are due 1, 3 and 5 edges after the edge that samples `start`. These correspond to a descriptor fault, a bound fault and a bitmap decision. A wait-state run shows that each stalled read cycle adds exactly one edge. After the start edge, the bench counts rising edges and samples the outputs on the following falling edge. It then compares the count at which a result pulse first appears with the expected count, and it also compares how many reads were acknowledged by then. The ignored-start case watches the outputs for several cycles past the single expected pulse.

// File: rtl/iopc_pkg.sv
package iopc_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_DESC,
    S_RD_MAP,
    S_BOUND,
    S_RD_BITS,
    S_TEST
  } state_e;

  // Control-to-datapath strobes
  typedef struct packed {
    logic latch;    // capture request and descriptor
    logic capMap;   // capture bitmap start offset and form byte offset
    logic capWord;  // capture the bitmap word
    logic selBits;  // address the bitmap word instead of the offset field
  } strobe_t;

  localparam logic [3:0] SEG_TYPE_OK = 4'b1001;
  localparam int unsigned MIN_LIMIT   = 103;
  localparam int unsigned MAP_PTR_OFS = 'h66;

endpackage

// File: rtl/iopc_datapath.sv
module iopc_datapath
  import iopc_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int LIMIT_W = 32,
  parameter int PORT_W  = 16,
  parameter int DATA_W  = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic [PORT_W-1:0]  portNum,
  input  logic [1:0]         accSize,
  input  logic               segPresent,
  input  logic [3:0]         segType,
  input  logic [ADDR_W-1:0]  segBase,
  input  logic [LIMIT_W-1:0] segLimit,
  input  logic [DATA_W-1:0]  memData,
  output logic [ADDR_W-1:0]  memAddr,
  output logic               descOk,
  output logic               boundOk,
  output logic               bitsClear
);

  localparam int IDX_W = PORT_W - 3;
  localparam int OFF_W = ((DATA_W > IDX_W) ? DATA_W : IDX_W) + 1;
  localparam int CMP_W = ((LIMIT_W > OFF_W) ? LIMIT_W : OFF_W) + 1;

  logic [PORT_W-1:0]  portQ;
  logic [1:0]         sizeQ;
  logic               presQ;
  logic [3:0]         typeQ;
  logic [ADDR_W-1:0]  baseQ;
  logic [LIMIT_W-1:0] limitQ;
  logic [OFF_W-1:0]   offQ;
  logic [DATA_W-1:0]  wordQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      portQ  <= '0;
      sizeQ  <= '0;
      presQ  <= 1'b0;
      typeQ  <= '0;
      baseQ  <= '0;
      limitQ <= '0;
      offQ   <= '0;
      wordQ  <= '0;
    end else begin
      if (stb.latch) begin
        portQ  <= portNum;
        sizeQ  <= accSize;
        presQ  <= segPresent;
        typeQ  <= segType;
        baseQ  <= segBase;
        limitQ <= segLimit;
      end
      if (stb.capMap) begin
        offQ <= OFF_W'(memData) + OFF_W'(portQ[PORT_W-1:3]);
      end
      if (stb.capWord) begin
        wordQ <= memData;
      end
    end
  end

  assign descOk  = presQ && (typeQ == SEG_TYPE_OK) &&
                   (limitQ >= LIMIT_W'(MIN_LIMIT));
  assign boundOk = (CMP_W'(offQ) + CMP_W'(1)) <= CMP_W'(limitQ);
  assign memAddr = baseQ + (stb.selBits ? ADDR_W'(offQ) : ADDR_W'(MAP_PTR_OFS));

  logic [DATA_W-1:0] shifted;
  logic [3:0]        sizeMask;

  always_comb begin
    shifted = wordQ >> portQ[2:0];
    case (sizeQ)
      2'b00:   sizeMask = 4'b0001;
      2'b01:   sizeMask = 4'b0011;
      default: sizeMask = 4'b1111;
    endcase
  end

  assign bitsClear = (shifted[3:0] & sizeMask) == 4'b0000;

endmodule

// File: rtl/iopc_ctrl.sv
module iopc_ctrl
  import iopc_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    memAck,
  input  logic    descOk,
  input  logic    boundOk,
  input  logic    bitsClear,
  output strobe_t stb,
  output logic    memReq,
  output logic    busy,
  output logic    permitOk,
  output logic    gpFault
);

  state_e state, nextState;
  logic   grantNext, faultNext;

  always_comb begin
    nextState = state;
    stb       = '0;
    grantNext = 1'b0;
    faultNext = 1'b0;
    case (state)
      S_IDLE: begin
        if (start) begin
          stb.latch = 1'b1;
          nextState = S_DESC;
        end
      end
      S_DESC: begin
        if (descOk) begin
          nextState = S_RD_MAP;
        end else begin
          faultNext = 1'b1;
          nextState = S_IDLE;
        end
      end
      S_RD_MAP: begin
        if (memAck) begin
          stb.capMap = 1'b1;
          nextState  = S_BOUND;
        end
      end
      S_BOUND: begin
        if (boundOk) begin
          nextState = S_RD_BITS;
        end else begin
          faultNext = 1'b1;
          nextState = S_IDLE;
        end
      end
      S_RD_BITS: begin
        stb.selBits = 1'b1;
        if (memAck) begin
          stb.capWord = 1'b1;
          nextState   = S_TEST;
        end
      end
      S_TEST: begin
        grantNext = bitsClear;
        faultNext = !bitsClear;
        nextState = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      permitOk <= 1'b0;
      gpFault  <= 1'b0;
    end else begin
      state    <= nextState;
      permitOk <= grantNext;
      gpFault  <= faultNext;
    end
  end

  assign memReq = (state == S_RD_MAP) || (state == S_RD_BITS);
  assign busy   = (state != S_IDLE);

endmodule

// File: rtl/io_perm_checker.sv
module io_perm_checker
  import iopc_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int LIMIT_W = 32,
  parameter int PORT_W  = 16,
  parameter int DATA_W  = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [PORT_W-1:0]  portNum,
  input  logic [1:0]         accSize,
  input  logic               segPresent,
  input  logic [3:0]         segType,
  input  logic [ADDR_W-1:0]  segBase,
  input  logic [LIMIT_W-1:0] segLimit,
  output logic               memReq,
  output logic [ADDR_W-1:0]  memAddr,
  input  logic               memAck,
  input  logic [DATA_W-1:0]  memData,
  output logic               busy,
  output logic               permitOk,
  output logic               gpFault
);

  strobe_t stb;
  logic    descOk, boundOk, bitsClear;

  iopc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .memAck(memAck),
    .descOk(descOk), .boundOk(boundOk), .bitsClear(bitsClear),
    .stb(stb), .memReq(memReq), .busy(busy),
    .permitOk(permitOk), .gpFault(gpFault)
  );

  iopc_datapath #(
    .ADDR_W(ADDR_W), .LIMIT_W(LIMIT_W), .PORT_W(PORT_W), .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .portNum(portNum), .accSize(accSize),
    .segPresent(segPresent), .segType(segType),
    .segBase(segBase), .segLimit(segLimit),
    .memData(memData), .memAddr(memAddr),
    .descOk(descOk), .boundOk(boundOk), .bitsClear(bitsClear)
  );

endmodule

// File: rtl/io_perm_checker_sva.sv
module io_perm_checker_sva #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              busy,
  input logic              memReq,
  input logic              memAck,
  input logic [ADDR_W-1:0] memAddr,
  input logic              permitOk,
  input logic              gpFault
);

  assert_one_result_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(permitOk && gpFault));

  assert_result_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    (permitOk || gpFault) |=> !(permitOk || gpFault));

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr)));

  assert_req_in_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> busy);

  assert_result_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    (permitOk || gpFault) |-> !busy);

  assert_start_taken_R8: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

endmodule

bind io_perm_checker io_perm_checker_sva #(.ADDR_W(ADDR_W)) u_sva (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy),
  .memReq(memReq), .memAck(memAck), .memAddr(memAddr),
  .permitOk(permitOk), .gpFault(gpFault)
);

// File: tb/tb_io_perm_checker.sv
module tb_io_perm_checker;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [15:0] portNum = '0;
  logic [1:0]  accSize = '0;
  logic        segPresent = 1'b1;
  logic [3:0]  segType = 4'b1001;
  logic [31:0] segBase = 32'h100;
  logic [31:0] segLimit = 32'h70;
  logic        memReq, memAck, busy, permitOk, gpFault;
  logic [31:0] memAddr;
  logic [15:0] memData;

  int errors = 0;
  int checks = 0;
  int waitStates = 0;
  int waitCnt = 0;
  int readCnt = 0;
  logic [31:0] firstAddr = '0, lastAddr = '0;
  logic [7:0] mem [1024];

  always #2.5 clk = ~clk;

  io_perm_checker dut (
    .clk(clk), .rstN(rstN), .start(start), .portNum(portNum), .accSize(accSize),
    .segPresent(segPresent), .segType(segType), .segBase(segBase), .segLimit(segLimit),
    .memReq(memReq), .memAddr(memAddr), .memAck(memAck), .memData(memData),
    .busy(busy), .permitOk(permitOk), .gpFault(gpFault)
  );

  // Memory model: little-endian 16-bit reads with programmable wait states
  assign memAck  = memReq && (waitCnt >= waitStates);
  assign memData = {mem[10'(memAddr + 32'd1)], mem[10'(memAddr)]};

  always @(posedge clk) begin
    if (memReq && !memAck) waitCnt <= waitCnt + 1;
    else waitCnt <= 0;
    if (memReq && memAck) begin
      readCnt   <= readCnt + 1;
      firstAddr <= lastAddr;
      lastAddr  <= memAddr;
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Issues one check; counts edges after the start edge until a result pulse
  task automatic runCheck(input string tag, input logic [15:0] p, input logic [1:0] s,
                          input logic expFault, input int expLat, input int expReads);
    int n = 0;
    int r0;
    logic gotFault = 1'b0;
    @(negedge clk);
    portNum = p; accSize = s; start = 1'b1;
    r0 = readCnt;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(posedge clk);
      @(negedge clk);
      n++;
      if (permitOk || gpFault) begin
        gotFault = gpFault;
        break;
      end
    end
    chk({tag, " R10 latency"}, n, expLat);
    chk({tag, " R6 R7 fault"}, gotFault, expFault);
    chk({tag, " R9 reads"}, readCnt - r0, expReads);
  endtask

  // {port, size, fault, latency}
  localparam logic [22:0] VEC [15] = '{
    {16'd0,     2'd0, 1'b0, 4'd5},
    {16'd8,     2'd0, 1'b1, 4'd5},
    {16'd9,     2'd2, 1'b0, 4'd5},
    {16'd14,    2'd1, 1'b1, 4'd5},
    {16'd13,    2'd1, 1'b0, 4'd5},
    {16'd14,    2'd0, 1'b0, 4'd5},
    {16'd17,    2'd2, 1'b1, 4'd5},
    {16'd17,    2'd3, 1'b1, 4'd5},
    {16'd21,    2'd2, 1'b0, 4'd5},
    {16'd31,    2'd1, 1'b1, 4'd5},
    {16'd36,    2'd0, 1'b1, 4'd5},
    {16'd60,    2'd0, 1'b0, 4'd5},
    {16'd63,    2'd2, 1'b1, 4'd5},
    {16'd64,    2'd0, 1'b1, 4'd3},
    {16'hFFFF,  2'd0, 1'b1, 4'd3}
  };

  initial begin
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL R7 watchdog actual=hung expected=result");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int lat;
    int pulses;
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    mem['h166] = 8'h68; mem['h167] = 8'h00;
    mem['h169] = 8'h81; mem['h16A] = 8'h10; mem['h16C] = 8'hFF; mem['h170] = 8'hFF;

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 memReq", memReq, 0);
    chk("R1 permit/fault", {permitOk, gpFault}, 0);
    rstN = 1'b1;

    // R3 R4 R6 table walk
    for (int i = 0; i < 15; i++) begin
      lat = int'(VEC[i][3:0]);
      runCheck($sformatf("vec%0d R6", i), VEC[i][22:7], VEC[i][6:5], VEC[i][4],
               lat, (lat == 5) ? 2 : (lat == 3) ? 1 : 0);
    end
    runCheck("R3 R4 addr", 16'd9, 2'd0, 1'b0, 5, 2);
    chk("R3 first read address", firstAddr, 32'h166);
    chk("R4 second read address", lastAddr, 32'h169);

    // R2 descriptor screening
    segPresent = 1'b0;
    runCheck("R2 not present", 16'd0, 2'd0, 1'b1, 1, 0);
    segPresent = 1'b1; segType = 4'b1011;
    runCheck("R2 bad type", 16'd0, 2'd0, 1'b1, 1, 0);
    segType = 4'b1001; segLimit = 32'd102;
    runCheck("R2 limit 102", 16'd0, 2'd0, 1'b1, 1, 0);
    segLimit = 32'd103;
    runCheck("R2 R5 limit 103", 16'd0, 2'd0, 1'b1, 3, 1);
    segLimit = 32'd105;
    runCheck("R5 equal bound", 16'd0, 2'd0, 1'b0, 5, 2);

    // R5 no wrap of the offset sum
    mem['h166] = 8'hFF; mem['h167] = 8'hFF;
    segLimit = 32'h11FFE;
    runCheck("R5 wide sum fault", 16'hFFFF, 2'd0, 1'b1, 3, 1);
    segLimit = 32'h11FFF;
    runCheck("R5 wide sum pass", 16'hFFFF, 2'd0, 1'b0, 5, 2);
    chk("R4 wide second address", lastAddr, 32'h120FE);
    mem['h166] = 8'h68; mem['h167] = 8'h00;
    segLimit = 32'h70;

    // R9 R10 wait states
    waitStates = 2;
    runCheck("R9 waits", 16'd8, 2'd0, 1'b1, 9, 2);
    waitStates = 0;

    // R8 start while busy ignored, inputs captured at accepted start
    @(negedge clk);
    portNum = 16'd0; accSize = 2'd0; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    @(posedge clk);
    @(negedge clk);
    start = 1'b1; portNum = 16'd8; segPresent = 1'b0;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    pulses = 0;
    for (int i = 0; i < 12; i++) begin
      if (permitOk) pulses++;
      if (gpFault) pulses += 100;
      @(posedge clk);
      @(negedge clk);
    end
    chk("R8 single permit, second start ignored", pulses, 1);
    chk("R8 idle after", busy, 0);
    segPresent = 1'b1;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule